// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Registers

This block gathers the interrupt conditions of one peripheral and reduces them to a single interrupt line. At the lower level, a set of latched per-source flags from the peripheral core is masked by its own enable register and folded into one summary request. At the upper level, that summary joins one latched internal error flag and a group of live source lines in a device status word. The status word is masked by a device enable word to give a pending view. A priority encoder turns the pending view into an index, and a single global enable bit gates the final output.

Software reaches the block through a plain synchronous register port: a write strobe, a byte address, write data, and read data that follows the address combinationally. Latched flags change state when software writes a one to them. This one write rule both injects a test interrupt and acknowledges a condition. A keyed write to the reset word clears every register. The interrupt output is a flip-flop.

Top module: `irq_hub`

## Requirements
- R1: After reset every register reads zero, the priority index (offset 24) reads 128, and `irqOut` is 0.
- R2: Offset 4 reads device status AND device enable (offset 8). Writes to offset 4 change nothing.
- R3: Device status (offset 0) bits other than bit 0 follow their live inputs with no delay: bit `IP_BIT` is the IP summary OR `devSrc[IP_BIT]`, and every other bit i is `devSrc[i]`. Writes do not affect these bits.
- R4: Device status bit 0 is a latched error flag. A rising edge on `devSrc[0]` sets it. Writing a 1 to bit 0 of offset 0 inverts it, and writing a 0 leaves it unchanged.
- R5: IP status (offset 32) bits are latched. A rising edge on `ipSrc[i]` sets bit i, a falling edge leaves it unchanged, and writing a 1 to bit i inverts it.
- R6: When a hardware rising edge and a software invert hit the same latched bit in the same cycle, the bit becomes 1.
- R7: The IP summary is the OR of IP status AND IP enable (offset 40). It appears live on device status bit `IP_BIT`.
- R8: Offset 24 reads the index of the lowest-numbered set pending bit, which is the highest priority. It reads 128 when no pending bit is set.
- R9: Only bit 31 of the global enable word (offset 28) is stored. All other bits read as zero.
- R10: `irqOut` is a register that takes the value (global enable AND any pending bit) one cycle after those inputs change.
- R11: Writing 0xA to offset 64 clears every register to zero. Writing any other value there has no effect.
- R12: Reads of offsets with no register return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 7 | Byte address for both reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| devSrc | input | DEV_W | Live device-level sources. Bit 0 is the error event input. |
| ipSrc | input | NUM_IP | IP-level sources, edge-latched |
| irqOut | output | 1 | Registered interrupt output |

## Verification
The bench builds the block with `NUM_IP = 6` and `IP_BIT = 5` instead of the defaults. This proves that the summary lands on a movable status bit and that IP enable and status words narrower than the bus are zero-extended on read. `DEV_W` stays at 32, so the priority index can reach 31 and the edge case where only the top bit is pending is exercised. The sequence also covers a hardware set that coincides with a software invert, and the one-cycle output lag after both enable changes and source changes.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 7;
  localparam int ID_W    = 8;
  localparam int GIE_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_DSTAT  = 7'd0;
  localparam logic [ADDR_W-1:0] OFS_DPEND  = 7'd4;
  localparam logic [ADDR_W-1:0] OFS_DEN    = 7'd8;
  localparam logic [ADDR_W-1:0] OFS_ID     = 7'd24;
  localparam logic [ADDR_W-1:0] OFS_GIE    = 7'd28;
  localparam logic [ADDR_W-1:0] OFS_IPSTAT = 7'd32;
  localparam logic [ADDR_W-1:0] OFS_IPEN   = 7'd40;
  localparam logic [ADDR_W-1:0] OFS_RST    = 7'd64;

  localparam logic [REG_W-1:0] RST_KEY = 32'h0000_000A;
  localparam logic [ID_W-1:0]  NO_ID   = 8'd128;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DSTAT, SEL_DPEND, SEL_DEN, SEL_ID, SEL_GIE, SEL_IPSTAT, SEL_IPEN
  } rdSel_t;

  typedef struct packed {
    logic wrDevStat;
    logic wrDevEn;
    logic wrGie;
    logic wrIpStat;
    logic wrIpEn;
    logic softRst;
  } strobe_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output strobe_t           strb,
  output rdSel_t            rdSel
);
  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    case (addr)
      OFS_DSTAT:  begin rdSel = SEL_DSTAT;  strb.wrDevStat = wrEn; end
      OFS_DPEND:  rdSel = SEL_DPEND;
      OFS_DEN:    begin rdSel = SEL_DEN;    strb.wrDevEn   = wrEn; end
      OFS_ID:     rdSel = SEL_ID;
      OFS_GIE:    begin rdSel = SEL_GIE;    strb.wrGie     = wrEn; end
      OFS_IPSTAT: begin rdSel = SEL_IPSTAT; strb.wrIpStat  = wrEn; end
      OFS_IPEN:   begin rdSel = SEL_IPEN;   strb.wrIpEn    = wrEn; end
      OFS_RST:    strb.softRst = wrEn && (wrData == RST_KEY);
      default:    rdSel = SEL_NONE;
    endcase
  end

  // R12: at most one register is targeted per write, none when idle
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strb == '0));
endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int DEV_W  = 32,
  parameter int NUM_IP = 8,
  parameter int IP_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  rdSel_t            rdSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic [DEV_W-1:0]  devSrc,
  input  logic [NUM_IP-1:0] ipSrc,
  output logic [REG_W-1:0]  rdData,
  output logic              irqOut
);
  localparam int IDX_W = $clog2(DEV_W);

  logic              errLatchQ, errPrevQ, gieQ, irqQ;
  logic [DEV_W-1:0]  devEnQ;
  logic [NUM_IP-1:0] ipStatQ, ipEnQ, ipPrevQ;

  logic              errRise, ipReq;
  logic [NUM_IP-1:0] ipRise;
  logic [DEV_W-1:0]  devStat, pend;
  logic [ID_W-1:0]   idVal;

  assign errRise = devSrc[0] & ~errPrevQ;
  assign ipRise  = ipSrc & ~ipPrevQ;
  assign ipReq   = |(ipStatQ & ipEnQ);

  // Device status composition: bit 0 latched, IP_BIT carries the IP summary
  for (genvar i = 0; i < DEV_W; i++) begin : g_stat
    if (i == 0) begin : g_err
      assign devStat[i] = errLatchQ;
    end else if (i == IP_BIT) begin : g_ip
      assign devStat[i] = ipReq | devSrc[i];
    end else begin : g_live
      assign devStat[i] = devSrc[i];
    end
  end

  assign pend = devStat & devEnQ;

  always_comb begin
    idVal = NO_ID;
    for (int i = DEV_W - 1; i >= 0; i--) begin
      if (pend[i]) idVal = ID_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errLatchQ <= 1'b0;
      errPrevQ  <= 1'b0;
      gieQ      <= 1'b0;
      irqQ      <= 1'b0;
      devEnQ    <= '0;
      ipStatQ   <= '0;
      ipEnQ     <= '0;
      ipPrevQ   <= '0;
    end else begin
      errPrevQ <= devSrc[0];
      ipPrevQ  <= ipSrc;
      irqQ     <= gieQ & (|pend);
      if (strb.softRst) begin
        errLatchQ <= 1'b0;
        gieQ      <= 1'b0;
        devEnQ    <= '0;
        ipStatQ   <= '0;
        ipEnQ     <= '0;
      end else begin
        errLatchQ <= (errLatchQ ^ (strb.wrDevStat & wrData[0])) | errRise;
        ipStatQ   <= (ipStatQ ^ ({NUM_IP{strb.wrIpStat}} & wrData[NUM_IP-1:0])) | ipRise;
        if (strb.wrDevEn) devEnQ <= wrData[DEV_W-1:0];
        if (strb.wrGie)   gieQ   <= wrData[GIE_BIT];
        if (strb.wrIpEn)  ipEnQ  <= wrData[NUM_IP-1:0];
      end
    end
  end

  always_comb begin
    case (rdSel)
      SEL_DSTAT:  rdData = REG_W'(devStat);
      SEL_DPEND:  rdData = REG_W'(pend);
      SEL_DEN:    rdData = REG_W'(devEnQ);
      SEL_ID:     rdData = REG_W'(idVal);
      SEL_GIE:    rdData = REG_W'(gieQ) << GIE_BIT;
      SEL_IPSTAT: rdData = REG_W'(ipStatQ);
      SEL_IPEN:   rdData = REG_W'(ipEnQ);
      default:    rdData = '0;
    endcase
  end

  assign irqOut = irqQ;

  // R10: the output can only be high if the global enable was set a cycle earlier
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(gieQ));
  // R8: a reported index always points at a set pending bit
  p_id_points_r8: assert property (@(posedge clk) disable iff (!rstN)
    (idVal != NO_ID) |-> pend[idVal[IDX_W-1:0]]);
  // R6: a hardware rising edge always leaves its latched bit at 1
  p_hw_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.softRst |=> ((ipStatQ & $past(ipRise)) == $past(ipRise)));
  // R9: the global enable moves only on its own write or a soft reset
  p_gie_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrGie && !strb.softRst) |=> $stable(gieQ));
  // R11: a keyed reset write leaves all enables cleared
  p_soft_rst_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (devEnQ == '0 && ipEnQ == '0 && !gieQ));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int DEV_W  = 32,
  parameter int NUM_IP = 8,
  parameter int IP_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [6:0]        addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [DEV_W-1:0]  devSrc,
  input  logic [NUM_IP-1:0] ipSrc,
  output logic              irqOut
);
  strobe_t strb;
  rdSel_t  rdSel;

  irq_hub_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .rdSel(rdSel)
  );

  irq_hub_dp #(.DEV_W(DEV_W), .NUM_IP(NUM_IP), .IP_BIT(IP_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .wrData(wrData),
    .devSrc(devSrc), .ipSrc(ipSrc), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int DEV_W  = 32;
  localparam int NUM_IP = 6;
  localparam int IP_BIT = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [6:0]        addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [DEV_W-1:0]  devSrc = '0;
  logic [NUM_IP-1:0] ipSrc = '0;
  logic              irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [6:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  irq_hub #(.DEV_W(DEV_W), .NUM_IP(NUM_IP), .IP_BIT(IP_BIT)) u_irq_hub (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .devSrc(devSrc), .ipSrc(ipSrc), .irqOut(irqOut)
  );

  // Monitor: compares queued expectations one time unit after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = it.isIrq ? {31'b0, irqOut} : rdData;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, act, it.exp);
      end
    end
  end

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.isIrq = 1'b0; it.a = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    item_t it;
    it.isIrq = 1'b1; it.a = '0; it.exp = {31'b0, e}; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setDev(input logic [31:0] v);
    devSrc = v;
    @(negedge clk);
  endtask

  task automatic setIp(input logic [NUM_IP-1:0] v);
    ipSrc = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(7'd0,  32'h0, "R1 dev status");
    rd(7'd4,  32'h0, "R1 pending");
    rd(7'd8,  32'h0, "R1 dev enable");
    rd(7'd24, 32'd128, "R1 id");
    rd(7'd28, 32'h0, "R1 global enable");
    rd(7'd32, 32'h0, "R1 ip status");
    rd(7'd40, 32'h0, "R1 ip enable");
    chkIrq(1'b0, "R1 irq");

    // R3 live bits, writes ignored
    setDev(32'h0000_0104);
    rd(7'd0, 32'h0000_0104, "R3 live view");
    wr(7'd0, 32'hFFFF_FFFE);
    rd(7'd0, 32'h0000_0104, "R3 write ignored");

    // R4 latched error bit
    wr(7'd0, 32'h1);
    rd(7'd0, 32'h0000_0105, "R4 invert sets");
    wr(7'd0, 32'h1);
    rd(7'd0, 32'h0000_0104, "R4 invert clears");
    setDev(32'h0000_0105);
    rd(7'd0, 32'h0000_0105, "R4 hw edge sets");
    setDev(32'h0000_0104);
    rd(7'd0, 32'h0000_0105, "R4 stays latched");
    wr(7'd0, 32'h0);
    rd(7'd0, 32'h0000_0105, "R4 write zero no change");
    wr(7'd0, 32'h1);
    rd(7'd0, 32'h0000_0104, "R4 acknowledge");

    // R2 pending view, read-only
    wr(7'd8, 32'hFFFF_FFFF);
    rd(7'd4, 32'h0000_0104, "R2 pending and");
    wr(7'd4, 32'h0);
    rd(7'd4, 32'h0000_0104, "R2 read only");

    // R8 priority index
    rd(7'd24, 32'd2, "R8 lowest bit");
    setDev(32'h8000_0000);
    rd(7'd24, 32'd31, "R8 top bit");
    setDev(32'h0);
    rd(7'd24, 32'd128, "R8 none pending");

    // R9 global enable storage
    wr(7'd28, 32'hFFFF_FFFF);
    rd(7'd28, 32'h8000_0000, "R9 only bit 31");
    wr(7'd28, 32'h7FFF_FFFF);
    rd(7'd28, 32'h0, "R9 bit 31 clear");
    wr(7'd28, 32'h8000_0000);

    // R10 registered output
    setDev(32'h10);
    chkIrq(1'b1, "R10 source raises irq");
    wr(7'd8, 32'h0);
    chkIrq(1'b1, "R10 one-cycle lag");
    chkIrq(1'b0, "R10 enable cleared");
    wr(7'd8, 32'h10);
    chkIrq(1'b0, "R10 lag on enable");
    chkIrq(1'b1, "R10 enable set");
    wr(7'd28, 32'h0);
    chkIrq(1'b1, "R10 lag on global");
    chkIrq(1'b0, "R10 global gate");
    wr(7'd8, 32'h0);
    setDev(32'h0);

    // R7 IP summary onto device bit IP_BIT
    wr(7'd40, 32'h3);
    setIp(6'h02);
    rd(7'd32, 32'h02, "R5 hw edge sets");
    rd(7'd0, 32'h20, "R7 summary on bit 5");
    wr(7'd40, 32'h1);
    rd(7'd0, 32'h0, "R7 masked");
    rd(7'd40, 32'h1, "R7 ip enable readback");

    // R5 invert rule and falling edge
    wr(7'd32, 32'h02);
    rd(7'd32, 32'h0, "R5 acknowledge");
    wr(7'd32, 32'h21);
    rd(7'd32, 32'h21, "R5 software set");
    setIp(6'h00);
    rd(7'd32, 32'h21, "R5 fall no effect");
    rd(7'd0, 32'h20, "R7 enabled bit set");

    // R6 coincident hardware set and software invert
    ipSrc = 6'h01;
    wr(7'd32, 32'h01);
    rd(7'd32, 32'h21, "R6 hw set wins");
    wr(7'd32, 32'h01);
    rd(7'd32, 32'h20, "R5 plain invert clears");

    // R12 reserved offsets
    rd(7'd12, 32'h0, "R12 reserved read");
    rd(7'd44, 32'h0, "R12 reserved read");
    wr(7'd12, 32'hFFFF_FFFF);
    wr(7'd44, 32'hFFFF_FFFF);
    rd(7'd8,  32'h0,  "R12 dev enable untouched");
    rd(7'd40, 32'h1,  "R12 ip enable untouched");
    rd(7'd32, 32'h20, "R12 ip status untouched");

    // R11 keyed soft reset
    wr(7'd28, 32'h8000_0000);
    wr(7'd8,  32'h5);
    wr(7'd64, 32'h5);
    rd(7'd8,  32'h5, "R11 wrong key");
    rd(7'd28, 32'h8000_0000, "R11 wrong key");
    wr(7'd64, 32'hA);
    rd(7'd8,  32'h0, "R11 dev enable");
    rd(7'd28, 32'h0, "R11 global enable");
    rd(7'd40, 32'h0, "R11 ip enable");
    rd(7'd32, 32'h0, "R11 ip status");
    rd(7'd0,  32'h0, "R11 dev status");
    rd(7'd24, 32'd128, "R11 id");

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule